// File: doc/BRIEF.md
# Sentinel-Terminated Streaming Code Loader

This block takes a byte stream on a valid/ready input and stores it into sequential memory locations, ready for a processor to run. It always keeps the two most recent bytes in a small history. Each accepted byte writes out the byte that arrived two acceptances earlier, so the last two bytes of the stream are never stored. Those two bytes form a 16-bit word, with the older byte as the high half. The loader compares that word against two terminator codes.

The run code ends loading and launches the stored program. The patch code first appends a three-byte jump to the restart address just after the last stored byte, and then launches. Launching is a one-cycle start pulse together with the entry address. After that the loader accepts nothing until a synchronous reset. The write pointer starts two locations below the entry address. Because of this, the two writes that would carry empty history are dropped, and the first real byte lands at the entry address.

Top module: `stream_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it, `in_ready` is 1, `mem_we` is 0 and `start` is 0.
- R2: The first two bytes accepted after reset cause no memory write.
- R3: Every later acceptance raises `mem_we` for one cycle, on the edge after the accepting edge. It writes the byte accepted two acceptances earlier. The first such write goes to address 0x1000, and each acceptance after it adds one to the address.
- R4: When the byte accepted just before the current one, taken as the high half, and the current byte form 0xEDC3, no further write follows that acceptance's own write. `start` is high for exactly one cycle, one cycle after that write.
- R5: When the word is 0xEDBF, the bytes 0xC3, 0x00, 0x00 are written on three consecutive cycles after the acceptance's own write. They go to the three addresses that follow it. `start` pulses in the next cycle.
- R6: The two terminator bytes are never written to memory.
- R7: A pair that matches neither code, including 0xED followed by some other byte and 0xC3 not preceded by 0xED, does not end loading.
- R8: `in_ready` is 0 from the cycle after a terminator is accepted until reset. Bytes offered in that time produce no write and no second `start`.
- R9: `start_addr` is 0x1000.
- R10: A reset in the middle of a load restarts the sequence. The next load again drops two writes and begins at 0x1000.
- R11: Cycles with `in_valid` low, while `in_ready` is 1, produce no write and leave the history and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Loader accepts a byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| start | output | 1 | One-cycle launch pulse |
| start_addr | output | 16 | Program entry address |

## Verification
The bench builds the loader with its default parameters. These are 16-bit addresses and 8-bit data, a load base two below the entry address 0x1000, the terminators 0xEDC3 and 0xEDBF, and a restart address of zero.

Both terminators share the high byte 0xED. This lets the stream contain near misses next to real matches: 0xED followed by another byte, and a lone 0xC3. With a load base just below the entry address, the two dropped writes and the pointer step across 0x0FFF to 0x1000 can be seen at the write port.

// File: rtl/stream_loader_pkg.sv
package stream_loader_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_PATCH  = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_HALT   = 2'd3
    } ld_state_e;

    // bytes appended by the patch terminator: opcode, low address, high address
    localparam int PATCH_LEN = 3;
    // bytes held back before the first real write
    localparam int HIST_DEPTH = 2;

endpackage

// File: rtl/sl_history.sv
module sl_history #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] older,
    output logic [DW-1:0] newer,
    output logic [1:0]    fill
);

    typedef struct packed {
        logic [DW-1:0] older;
        logic [DW-1:0] newer;
        logic [1:0]    fill;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift) begin
            hist_d.older = hist_q.newer;
            hist_d.newer = din;
            if (hist_q.fill != 2'd2) begin
                hist_d.fill = hist_q.fill + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign older = hist_q.older;
    assign newer = hist_q.newer;
    assign fill  = hist_q.fill;

endmodule

// File: rtl/sl_term_detect.sv
module sl_term_detect #(
    parameter int              DW         = 8,
    parameter logic [2*DW-1:0] TERM_RUN   = 16'hEDC3,
    parameter logic [2*DW-1:0] TERM_PATCH = 16'hEDBF
) (
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    input  logic          hi_valid,
    output logic          hit_run,
    output logic          hit_patch
);

    localparam int NUM_CODES = 2;
    localparam logic [2*DW-1:0] CODES [NUM_CODES] = '{TERM_RUN, TERM_PATCH};

    logic [NUM_CODES-1:0] hit;
    logic [2*DW-1:0]      word;

    assign word = {hi, lo};

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
        assign hit[g] = hi_valid && (word == CODES[g]);
    end

    assign hit_run   = hit[0];
    assign hit_patch = hit[1];

endmodule

// File: rtl/stream_loader.sv
module stream_loader #(
    parameter int              AW           = 16,
    parameter int              DW           = 8,
    parameter logic [AW-1:0]   LOAD_BASE    = 16'h0FFE,
    parameter logic [AW-1:0]   ENTRY_ADDR   = 16'h1000,
    parameter logic [2*DW-1:0] TERM_RUN     = 16'hEDC3,
    parameter logic [2*DW-1:0] TERM_PATCH   = 16'hEDBF,
    parameter logic [DW-1:0]   JUMP_OP      = 8'hC3,
    parameter logic [2*DW-1:0] RESTART_ADDR = 16'h0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          start,
    output logic [AW-1:0] start_addr
);
    import stream_loader_pkg::*;

    localparam logic [1:0] FULL     = 2'(HIST_DEPTH);
    localparam logic [1:0] LAST_IDX = 2'(PATCH_LEN - 1);

    typedef struct packed {
        ld_state_e     state;
        logic [1:0]    pidx;
        logic [AW-1:0] ptr;
        logic          we;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic          start;
    } loader_t;

    loader_t cur_q, nxt_d;

    logic          accept;
    logic [DW-1:0] h_older;
    logic [DW-1:0] h_newer;
    logic [1:0]    h_fill;
    logic          hit_run;
    logic          hit_patch;

    function automatic logic [DW-1:0] patch_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    patch_byte = JUMP_OP;
            2'd1:    patch_byte = RESTART_ADDR[DW-1:0];
            default: patch_byte = RESTART_ADDR[2*DW-1:DW];
        endcase
    endfunction

    assign in_ready = (cur_q.state == ST_LOAD);
    assign accept   = in_valid && in_ready;

    sl_history #(.DW(DW)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .shift (accept),
        .din   (in_data),
        .older (h_older),
        .newer (h_newer),
        .fill  (h_fill)
    );

    // word after the shift: previous newest byte high, incoming byte low
    sl_term_detect #(
        .DW         (DW),
        .TERM_RUN   (TERM_RUN),
        .TERM_PATCH (TERM_PATCH)
    ) u_term (
        .hi        (h_newer),
        .lo        (in_data),
        .hi_valid  (h_fill != 2'd0),
        .hit_run   (hit_run),
        .hit_patch (hit_patch)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.we    = 1'b0;
        nxt_d.start = 1'b0;
        case (cur_q.state)
            ST_LOAD: begin
                if (accept) begin
                    nxt_d.we    = (h_fill == FULL);
                    nxt_d.waddr = cur_q.ptr;
                    nxt_d.wdata = h_older;
                    nxt_d.ptr   = cur_q.ptr + 1'b1;
                    if (hit_run) begin
                        nxt_d.state = ST_LAUNCH;
                    end else if (hit_patch) begin
                        nxt_d.state = ST_PATCH;
                        nxt_d.pidx  = 2'd0;
                    end
                end
            end
            ST_PATCH: begin
                nxt_d.we    = 1'b1;
                nxt_d.waddr = cur_q.ptr;
                nxt_d.wdata = patch_byte(cur_q.pidx);
                nxt_d.ptr   = cur_q.ptr + 1'b1;
                if (cur_q.pidx == LAST_IDX) begin
                    nxt_d.state = ST_LAUNCH;
                end else begin
                    nxt_d.pidx = cur_q.pidx + 2'd1;
                end
            end
            ST_LAUNCH: begin
                nxt_d.start = 1'b1;
                nxt_d.state = ST_HALT;
            end
            default: begin
                nxt_d.state = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= '0;
            cur_q.state <= ST_LOAD;
            cur_q.ptr   <= LOAD_BASE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_we     = cur_q.we;
    assign mem_addr   = cur_q.waddr;
    assign mem_wdata  = cur_q.wdata;
    assign start      = cur_q.start;
    assign start_addr = ENTRY_ADDR;

endmodule

// File: rtl/stream_loader_chk.sv
module stream_loader_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          start
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    p_quiet_after_start_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> (!mem_we && !in_ready));

    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> !in_ready);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ONE));

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(in_ready) && !$past(in_valid)) |-> !mem_we);

endmodule

bind stream_loader stream_loader_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .start    (start)
);

// File: tb/stream_loader_test.sv
module stream_loader_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {gap_before, in_byte, exp_we, exp_addr, exp_data}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 8'h11, 1'b0, 16'h0000, 8'h00},
        {1'b0, 8'h22, 1'b0, 16'h0000, 8'h00},
        {1'b0, 8'hED, 1'b1, 16'h1000, 8'h11},
        {1'b1, 8'h44, 1'b1, 16'h1001, 8'h22},
        {1'b0, 8'hC3, 1'b1, 16'h1002, 8'hED},
        {1'b0, 8'h55, 1'b1, 16'h1003, 8'h44},
        {1'b1, 8'hED, 1'b1, 16'h1004, 8'hC3},
        {1'b0, 8'h66, 1'b1, 16'h1005, 8'h55},
        {1'b0, 8'hED, 1'b1, 16'h1006, 8'hED},
        {1'b0, 8'hC3, 1'b1, 16'h1007, 8'h66}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        start;
    logic [15:0] start_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nlog = 0;
    int nstart = 0;
    int start_cyc = 0;
    logic [15:0] log_addr [64];
    logic [7:0]  log_data [64];
    int          log_cyc  [64];
    bit done = 0;

    stream_loader uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .start      (start),
        .start_addr (start_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && mem_we && nlog < 64) begin
            log_addr[nlog] = mem_addr;
            log_data[nlog] = mem_wdata;
            log_cyc[nlog]  = cyc;
            nlog = nlog + 1;
        end
        if (!rst && start) begin
            nstart = nstart + 1;
            start_cyc = cyc;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        nlog = 0;
        nstart = 0;
    endtask

    // offer one byte; returns just after the accepting edge
    task automatic send(input logic [7:0] b);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", {31'd0, in_ready}, 32'd1);
        chk("R1 we in reset", {31'd0, mem_we}, 32'd0);
        chk("R1 start in reset", {31'd0, start}, 32'd0);
        do_reset();
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, in_ready}, 32'd1);
        chk("R1 we after reset", {31'd0, mem_we}, 32'd0);
        chk("R9 entry address", {16'd0, start_addr}, 32'h1000);

        // table walk: run terminator with near misses and bubbles
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][33]) begin
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    chk("R11 bubble no write", {31'd0, mem_we}, 32'd0);
                end
            end
            send(VEC[i][32:25]);
            @(negedge clk);
            chk($sformatf("R2 R3 we vec %0d", i), {31'd0, mem_we}, {31'd0, VEC[i][24]});
            if (VEC[i][24]) begin
                chk($sformatf("R3 addr vec %0d", i), {16'd0, mem_addr}, {16'd0, VEC[i][23:8]});
                chk($sformatf("R3 R7 data vec %0d", i), {24'd0, mem_wdata}, {24'd0, VEC[i][7:0]});
            end
        end
        chk("R8 ready low after run code", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        chk("R4 start pulse", {31'd0, start}, 32'd1);
        chk("R4 R6 no write with start", {31'd0, mem_we}, 32'd0);
        @(negedge clk);
        chk("R4 start one cycle", {31'd0, start}, 32'd0);
        chk("R6 write count run", nlog, 32'd8);

        // offered bytes after launch are ignored
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data = 8'hED;
        repeat (3) @(posedge clk);
        #1;
        in_data = 8'hC3;
        repeat (3) @(posedge clk);
        #1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 no writes after start", nlog, 32'd8);
        chk("R8 no second start", nstart, 32'd1);
        chk("R8 ready stays low", {31'd0, in_ready}, 32'd0);

        // patch terminator
        do_reset();
        send(8'h01);
        send(8'h02);
        send(8'h03);
        send(8'hED);
        send(8'hBF);
        @(negedge clk);
        chk("R8 ready low during patch", {31'd0, in_ready}, 32'd0);
        repeat (6) @(negedge clk);
        chk("R5 R6 write count patch", nlog, 32'd6);
        chk("R5 patch addr 0", {16'd0, log_addr[3]}, 32'h1003);
        chk("R5 patch data 0", {24'd0, log_data[3]}, 32'hC3);
        chk("R5 patch addr 1", {16'd0, log_addr[4]}, 32'h1004);
        chk("R5 patch data 1", {24'd0, log_data[4]}, 32'h00);
        chk("R5 patch addr 2", {16'd0, log_addr[5]}, 32'h1005);
        chk("R5 patch data 2", {24'd0, log_data[5]}, 32'h00);
        chk("R5 last program byte", {8'd0, log_addr[2], log_data[2]}, 32'h100203);
        chk("R5 patch back to back", log_cyc[5] - log_cyc[2], 32'd3);
        chk("R5 start after patch", start_cyc - log_cyc[5], 32'd1);
        chk("R5 single start", nstart, 32'd1);

        // reset in the middle of a load
        do_reset();
        send(8'hAA);
        send(8'hBB);
        send(8'hCC);
        do_reset();
        @(negedge clk);
        chk("R10 ready after mid reset", {31'd0, in_ready}, 32'd1);
        send(8'h77);
        send(8'h88);
        send(8'hED);
        send(8'hC3);
        repeat (3) @(negedge clk);
        chk("R10 writes after reload", nlog, 32'd2);
        chk("R10 first addr", {16'd0, log_addr[0]}, 32'h1000);
        chk("R10 first data", {24'd0, log_data[0]}, 32'h77);
        chk("R10 second data", {24'd0, log_data[1]}, 32'h88);
        chk("R4 start after reload", nstart, 32'd1);

        // terminator alone: nothing stored, still launches
        do_reset();
        send(8'hED);
        send(8'hC3);
        repeat (3) @(negedge clk);
        chk("R2 R6 bare terminator no write", nlog, 32'd0);
        chk("R4 bare terminator start", nstart, 32'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule